// File: doc/BRIEF.md
# Streaming web and ping packet classifier

This block sits inline on a byte-wide valid/ready Ethernet frame stream. As each frame passes through, it inspects the Ethernet type and the IPv4 header. Using the header-length field, it then finds the start of the transport header and reads the first few bytes there.

Frames carrying TCP with port 80 on either side are counted as web traffic and continue on the main output. ICMP echo requests are counted as ping traffic and are steered to a side output. Every other frame goes to the main output without being counted. No byte of any frame is altered, dropped or reordered.

Incoming bytes go into a byte buffer. A per-frame verdict is pushed into a short verdict queue as soon as it is known, which is at the deciding header byte or at the end of the frame, whichever comes first. The output side releases the first byte of a frame only once that frame's verdict is at the head of the queue, and it keeps the same route until the frame's last byte has left. Both counters can be read at any time, wrap on overflow and have a synchronous clear.

Top module: `webping_sorter`

## Requirements
- R1: A frame can only be web or ping when bytes 12 and 13, taken high byte first, form 0x0800. Any other type value, including 0x0806 and the byte-swapped 0x0008, makes the frame "other".
- R2: The transport header starts at byte 14 + 4 × L, where L is the low nibble of byte 14. IPv4 option bytes between byte 34 and that point are skipped and never read as transport fields.
- R3: A header length L below 5 makes the frame "other".
- R4: A frame is web when byte 23 equals 6 and either the source port (transport bytes 0–1) or the destination port (transport bytes 2–3), read big-endian, equals 80. A web frame adds one to `web_count` and leaves on the main output.
- R5: A frame is ping when byte 23 equals 1 and transport byte 0 equals 8. A ping frame adds one to `ping_count` and leaves on the side output. An ICMP type of 0 (echo reply) is "other".
- R6: An "other" frame leaves on the main output and changes neither counter. Examples are UDP (protocol 17) on port 80 and TCP on ports other than 80.
- R7: A frame whose last byte comes before the byte that decides its class is "other". A frame that ends exactly on the deciding byte is classified normally.
- R8: Every frame is forwarded byte for byte, with its end marker on its final byte only, and frames leave in arrival order.
- R9: The route is fixed for a whole frame, and the main and side outputs are never valid in the same cycle.
- R10: While the selected output is not ready, its valid, data and last outputs hold steady and later frames wait behind it. The input stalls once the buffer is full.
- R11: `cnt_clr` sets both counters to zero on the next cycle and takes precedence over an increment in the same cycle.
- R12: After reset both outputs are invalid, both counters are zero and the input is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_clr | input | 1 | Synchronous clear of both counters |
| s_tdata | input | 8 | Input frame byte |
| s_tvalid | input | 1 | Input byte valid |
| s_tready | output | 1 | Input byte accepted when high with valid |
| s_tlast | input | 1 | Input byte is the last of its frame |
| m_tdata | output | 8 | Main output byte |
| m_tvalid | output | 1 | Main output byte valid |
| m_tready | input | 1 | Main output sink ready |
| m_tlast | output | 1 | Main output byte ends its frame |
| p_tdata | output | 8 | Side (ping) output byte |
| p_tvalid | output | 1 | Side output byte valid |
| p_tready | input | 1 | Side output sink ready |
| p_tlast | output | 1 | Side output byte ends its frame |
| web_count | output | CNT_W | Web frames seen, wrapping |
| ping_count | output | CNT_W | Echo-request frames seen, wrapping |

## Verification
The assertions assume that every frame is at least one byte long, that the input is not driven during reset, and that the buffer holds at least 78 bytes. With 78 bytes, the deepest deciding byte, at an IHL of 15, always fits even when the outputs are blocked. The bench keeps to these limits: its frames are 1 to 90 bytes long, it changes an input byte only after that byte has been accepted, and it uses the default buffer depth. It drives the two ready inputs in three ways: held high, toggled pseudo-randomly, and with the side sink held off for a long time. This exercises the hold-while-stalled and one-route-per-frame properties under real backpressure.

// File: rtl/webping_sorter.sv
module webping_sorter #(
  parameter int BUF_DEPTH = 128,
  parameter int CLS_DEPTH = 8,
  parameter int CNT_W     = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_clr,
  input  logic [7:0]       s_tdata,
  input  logic             s_tvalid,
  output logic             s_tready,
  input  logic             s_tlast,
  output logic [7:0]       m_tdata,
  output logic             m_tvalid,
  input  logic             m_tready,
  output logic             m_tlast,
  output logic [7:0]       p_tdata,
  output logic             p_tvalid,
  input  logic             p_tready,
  output logic             p_tlast,
  output logic [CNT_W-1:0] web_count,
  output logic [CNT_W-1:0] ping_count
);
  localparam int AW = $clog2(BUF_DEPTH);
  localparam int CW = $clog2(CLS_DEPTH);
  localparam logic [AW:0] B_FULL = (AW+1)'(BUF_DEPTH);
  localparam logic [CW:0] C_FULL = (CW+1)'(CLS_DEPTH);
  localparam logic [1:0] C_OTHER = 2'd0, C_WEB = 2'd1, C_PING = 2'd2;

  logic [8:0]    b_mem [BUF_DEPTH];
  logic [AW-1:0] b_wr, b_rd;
  logic [AW:0]   b_cnt;
  logic [1:0]    c_mem [CLS_DEPTH];
  logic [CW-1:0] c_wr, c_rd;
  logic [CW:0]   c_cnt;

  logic [7:0] idx, et_hi, proto, port_hi, t_off;
  logic [3:0] ihl;
  logic       src80, done;
  logic       dec_now;
  logic [1:0] dec_cls;
  logic       in_fire, out_fire, c_push, c_pop, head_ok, to_side, h_last;
  logic [7:0] h_data;

  assign s_tready = (b_cnt < B_FULL) && (c_cnt < C_FULL);
  assign in_fire  = s_tvalid && s_tready;
  assign t_off    = 8'd14 + {2'b00, ihl, 2'b00};

  always_comb begin
    dec_now = 1'b0;
    dec_cls = C_OTHER;
    if (!done) begin
      if (idx == 8'd13 && {et_hi, s_tdata} != 16'h0800)
        dec_now = 1'b1;
      else if (idx == 8'd14 && s_tdata[3:0] < 4'd5)
        dec_now = 1'b1;
      else if (idx == 8'd23 && s_tdata != 8'd6 && s_tdata != 8'd1)
        dec_now = 1'b1;
      else if (idx > 8'd23 && idx == t_off && proto == 8'd1) begin
        dec_now = 1'b1;
        dec_cls = (s_tdata == 8'd8) ? C_PING : C_OTHER;
      end else if (idx > 8'd23 && idx == t_off + 8'd3 && proto == 8'd6) begin
        dec_now = 1'b1;
        dec_cls = (src80 || {port_hi, s_tdata} == 16'd80) ? C_WEB : C_OTHER;
      end
      if (!dec_now && s_tlast) dec_now = 1'b1;
    end
  end

  assign c_push = in_fire && dec_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx  <= '0;
      done <= 1'b0;
    end else if (in_fire) begin
      idx  <= s_tlast ? 8'd0 : (idx == 8'hFF ? idx : idx + 8'd1);
      done <= s_tlast ? 1'b0 : (done | dec_now);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      et_hi   <= '0;
      ihl     <= '0;
      proto   <= '0;
      port_hi <= '0;
      src80   <= 1'b0;
    end else if (in_fire) begin
      if (idx == 8'd12) et_hi <= s_tdata;
      if (idx == 8'd14) ihl <= s_tdata[3:0];
      if (idx == 8'd23) proto <= s_tdata;
      if (idx == t_off || idx == t_off + 8'd2) port_hi <= s_tdata;
      if (idx == t_off + 8'd1) src80 <= ({port_hi, s_tdata} == 16'd80);
    end
  end

  always_ff @(posedge clk) begin
    if (in_fire) b_mem[b_wr] <= {s_tlast, s_tdata};
    if (c_push) c_mem[c_wr] <= dec_cls;
  end

  assign {h_last, h_data} = b_mem[b_rd];
  assign head_ok  = (b_cnt != '0) && (c_cnt != '0);
  assign to_side  = (c_mem[c_rd] == C_PING);
  assign m_tvalid = head_ok && !to_side;
  assign p_tvalid = head_ok && to_side;
  assign m_tdata  = h_data;
  assign p_tdata  = h_data;
  assign m_tlast  = h_last;
  assign p_tlast  = h_last;
  assign out_fire = (m_tvalid && m_tready) || (p_tvalid && p_tready);
  assign c_pop    = out_fire && h_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      b_wr  <= '0;
      b_rd  <= '0;
      b_cnt <= '0;
    end else begin
      if (in_fire)  b_wr <= (b_wr == AW'(BUF_DEPTH-1)) ? '0 : b_wr + 1'b1;
      if (out_fire) b_rd <= (b_rd == AW'(BUF_DEPTH-1)) ? '0 : b_rd + 1'b1;
      case ({in_fire, out_fire})
        2'b10:   b_cnt <= b_cnt + 1'b1;
        2'b01:   b_cnt <= b_cnt - 1'b1;
        default: b_cnt <= b_cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c_wr  <= '0;
      c_rd  <= '0;
      c_cnt <= '0;
    end else begin
      if (c_push) c_wr <= (c_wr == CW'(CLS_DEPTH-1)) ? '0 : c_wr + 1'b1;
      if (c_pop)  c_rd <= (c_rd == CW'(CLS_DEPTH-1)) ? '0 : c_rd + 1'b1;
      case ({c_push, c_pop})
        2'b10:   c_cnt <= c_cnt + 1'b1;
        2'b01:   c_cnt <= c_cnt - 1'b1;
        default: c_cnt <= c_cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || cnt_clr) begin
      web_count  <= '0;
      ping_count <= '0;
    end else if (c_push) begin
      if (dec_cls == C_WEB)  web_count  <= web_count + 1'b1;
      if (dec_cls == C_PING) ping_count <= ping_count + 1'b1;
    end
  end

  AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (rst) !(m_tvalid && p_tvalid)); // R9
  AST_SIDE_FRAME: assert property (@(posedge clk) disable iff (rst) (p_tvalid && p_tready && !p_tlast) |=> !m_tvalid); // R9
  AST_MAIN_FRAME: assert property (@(posedge clk) disable iff (rst) (m_tvalid && m_tready && !m_tlast) |=> !p_tvalid); // R9
  AST_MAIN_HOLD: assert property (@(posedge clk) disable iff (rst) (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast))); // R10
  AST_SIDE_HOLD: assert property (@(posedge clk) disable iff (rst) (p_tvalid && !p_tready) |=> (p_tvalid && $stable(p_tdata) && $stable(p_tlast))); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) (b_cnt <= B_FULL) && (c_cnt <= C_FULL)); // R10
  AST_WEB_STEP: assert property (@(posedge clk) disable iff (rst) !cnt_clr |=> (web_count == $past(web_count) || web_count == $past(web_count) + 1'b1)); // R4
  AST_PING_STEP: assert property (@(posedge clk) disable iff (rst) !cnt_clr |=> (ping_count == $past(ping_count) || ping_count == $past(ping_count) + 1'b1)); // R5
  AST_CLEAR: assert property (@(posedge clk) disable iff (rst) cnt_clr |=> (web_count == '0 && ping_count == '0)); // R11
  AST_RST_IDLE: assert property (@(posedge clk) rst |=> (!m_tvalid && !p_tvalid && s_tready && web_count == '0 && ping_count == '0)); // R12
endmodule

// File: tb/webping_sorter_tb.sv
module webping_sorter_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, cnt_clr;
  logic [7:0] s_tdata, m_tdata, p_tdata;
  logic s_tvalid, s_tready, s_tlast;
  logic m_tvalid, m_tready, m_tlast, p_tvalid, p_tready, p_tlast;
  logic [31:0] web_count, ping_count;

  webping_sorter u_dut (
    .clk(clk), .rst(rst), .cnt_clr(cnt_clr),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tlast(s_tlast),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast),
    .p_tdata(p_tdata), .p_tvalid(p_tvalid), .p_tready(p_tready), .p_tlast(p_tlast),
    .web_count(web_count), .ping_count(ping_count)
  );

  int n_chk = 0, n_bad = 0;

  // {ethertype, ver/ihl, protocol, transport bytes 0..3, length, class 0=other 1=web 2=ping}
  localparam int NV = 17;
  localparam logic [79:0] VEC [NV] = '{
    {16'h0800, 8'h45, 8'h06, 32'h0010_0050, 8'd60, 8'd1},
    {16'h0800, 8'h45, 8'h06, 32'h0050_1234, 8'd60, 8'd1},
    {16'h0800, 8'h45, 8'h06, 32'h1F90_1F90, 8'd60, 8'd0},
    {16'h0800, 8'h45, 8'h01, 32'h0800_1234, 8'd64, 8'd2},
    {16'h0800, 8'h45, 8'h01, 32'h0000_1234, 8'd64, 8'd0},
    {16'h0806, 8'h45, 8'h06, 32'h0050_0050, 8'd60, 8'd0},
    {16'h0008, 8'h45, 8'h06, 32'h0050_0050, 8'd60, 8'd0},
    {16'h0800, 8'h46, 8'h06, 32'h1F90_1F90, 8'd70, 8'd0},
    {16'h0800, 8'h46, 8'h06, 32'h3039_0050, 8'd70, 8'd1},
    {16'h0800, 8'h4F, 8'h01, 32'h0800_0000, 8'd90, 8'd2},
    {16'h0800, 8'h44, 8'h06, 32'h0050_0050, 8'd60, 8'd0},
    {16'h0800, 8'h45, 8'h06, 32'h1234_0050, 8'd36, 8'd0},
    {16'h0800, 8'h45, 8'h06, 32'h1234_0050, 8'd38, 8'd1},
    {16'h0800, 8'h45, 8'h11, 32'h0050_0050, 8'd60, 8'd0},
    {16'h0800, 8'h45, 8'h01, 32'h0800_0000, 8'd34, 8'd0},
    {16'h0800, 8'h45, 8'h01, 32'h0800_0000, 8'd35, 8'd2},
    {16'h0800, 8'h45, 8'h06, 32'h0050_0050, 8'd1,  8'd0}
  };
  string vtag [NV] = '{"R4", "R4", "R6", "R5", "R5", "R1", "R1", "R2", "R2", "R2",
                       "R3", "R7", "R7", "R6", "R7", "R7", "R7"};

  logic [7:0] fr [128];
  logic [7:0] mg [512];
  logic [7:0] pg [512];
  logic       ml [512];
  logic       pl [512];
  int m_n, p_n, m_fr, p_fr;
  int rmode = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic build(input logic [79:0] v);
    int t;
    t = 14 + 4 * int'(v[59:56]);
    for (int i = 0; i < 128; i++) fr[i] = 8'(i * 7 + 3);
    fr[12] = v[79:72];
    fr[13] = v[71:64];
    fr[14] = v[63:56];
    fr[23] = v[55:48];
    for (int i = 34; i < t; i++) fr[i] = i[0] ? 8'h50 : 8'h00;
    fr[t]   = v[47:40];
    fr[t+1] = v[39:32];
    fr[t+2] = v[31:24];
    fr[t+3] = v[23:16];
  endtask

  task automatic send(input int len);
    bit acc;
    for (int i = 0; i < len; i++) begin
      s_tdata  = fr[i];
      s_tlast  = (i == len - 1);
      s_tvalid = 1'b1;
      do begin
        #1;
        acc = s_tready;
        @(negedge clk);
      end while (!acc);
    end
    s_tvalid = 1'b0;
    s_tlast  = 1'b0;
  endtask

  task automatic clear_cap();
    m_n = 0; p_n = 0; m_fr = 0; p_fr = 0;
  endtask

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    m_tready = 1'b1;
    p_tready = 1'b1;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (rmode)
        1:       begin m_tready = lfsr[0]; p_tready = lfsr[3]; end
        2:       begin m_tready = 1'b1;    p_tready = 1'b0;    end
        default: begin m_tready = 1'b1;    p_tready = 1'b1;    end
      endcase
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (m_tvalid && m_tready) begin
        mg[m_n] = m_tdata; ml[m_n] = m_tlast; m_n++;
        if (m_tlast) m_fr++;
      end
      if (p_tvalid && p_tready) begin
        pg[p_n] = p_tdata; pl[p_n] = p_tlast; p_n++;
        if (p_tlast) p_fr++;
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    finish_run();
  end

  initial begin
    longint w0, p0;
    int len, cls, errs;
    clear_cap();
    rst = 1'b1; cnt_clr = 1'b0; s_tvalid = 1'b0; s_tlast = 1'b0; s_tdata = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    // R12 reset state
    chk(!m_tvalid && !p_tvalid, "R12 outputs idle", {m_tvalid, p_tvalid}, 0);
    chk(s_tready == 1'b1, "R12 input ready", s_tready, 1);
    chk(web_count == 0 && ping_count == 0, "R12 counters", web_count + ping_count, 0);
    @(negedge clk);

    for (int pass = 0; pass < 2; pass++) begin
      rmode = pass;
      for (int v = 0; v < NV; v++) begin
        build(VEC[v]);
        len = int'(VEC[v][15:8]);
        cls = int'(VEC[v][7:0]);
        clear_cap();
        w0 = web_count;
        p0 = ping_count;
        send(len);
        repeat (300) @(negedge clk);
        #1;
        errs = 0;
        if (cls == 2) begin
          for (int i = 0; i < p_n && i < len; i++)
            if (pg[i] != fr[i] || pl[i] != (i == len - 1)) errs++;
          chk(p_n == len && errs == 0, {vtag[v], " R8 side frame"}, p_n, len);
          chk(m_n == 0, {vtag[v], " main must be empty"}, m_n, 0);
        end else begin
          for (int i = 0; i < m_n && i < len; i++)
            if (mg[i] != fr[i] || ml[i] != (i == len - 1)) errs++;
          chk(m_n == len && errs == 0, {vtag[v], " R8 main frame"}, m_n, len);
          chk(p_n == 0, {vtag[v], " side must be empty"}, p_n, 0);
        end
        chk(longint'(web_count) - w0 == (cls == 1 ? 1 : 0), {vtag[v], " web count step"},
            longint'(web_count) - w0, (cls == 1 ? 1 : 0));
        chk(longint'(ping_count) - p0 == (cls == 2 ? 1 : 0), {vtag[v], " ping count step"},
            longint'(ping_count) - p0, (cls == 2 ? 1 : 0));
        @(negedge clk);
      end
    end

    // R8 R9: back-to-back frames under random backpressure
    rmode = 1;
    clear_cap();
    w0 = web_count;
    p0 = ping_count;
    build(VEC[0]); send(60);
    build(VEC[3]); send(64);
    build(VEC[2]); send(60);
    build(VEC[8]); send(70);
    repeat (800) @(negedge clk);
    #1;
    chk(m_fr == 3 && m_n == 190, "R9 main frames back-to-back", m_n, 190);
    chk(p_fr == 1 && p_n == 64, "R9 side frames back-to-back", p_n, 64);
    chk(longint'(web_count) - w0 == 2, "R4 web count back-to-back", longint'(web_count) - w0, 2);
    chk(longint'(ping_count) - p0 == 1, "R5 ping count back-to-back", longint'(ping_count) - p0, 1);
    @(negedge clk);

    // R10: side sink blocked, later web frame must wait behind the ping frame
    rmode = 2;
    @(negedge clk);
    clear_cap();
    build(VEC[3]); send(64);
    build(VEC[0]); send(60);
    repeat (200) @(negedge clk);
    #1;
    chk(m_n == 0, "R10 main waits behind stalled side", m_n, 0);
    chk(p_tvalid == 1'b1, "R10 side held valid", p_tvalid, 1);
    @(negedge clk);
    rmode = 0;
    repeat (300) @(negedge clk);
    #1;
    chk(p_fr == 1 && p_n == 64, "R10 side drains after release", p_n, 64);
    chk(m_fr == 1 && m_n == 60, "R10 main drains after release", m_n, 60);
    chk(web_count != 0 && ping_count != 0, "R11 counters nonzero before clear", web_count, 1);
    @(negedge clk);

    // R11 synchronous clear
    cnt_clr = 1'b1;
    @(negedge clk);
    cnt_clr = 1'b0;
    #1;
    chk(web_count == 0, "R11 web cleared", web_count, 0);
    chk(ping_count == 0, "R11 ping cleared", ping_count, 0);
    @(negedge clk);

    finish_run();
  end
endmodule